// File: doc/BRIEF.md
# Control Register Write Target for a Two-Wire Serial Bus

This block is a write-only I2C target that loads a small bank of 8-bit control registers for a display deflection controller. The bus master sets one register per transaction: START, the device byte, a subaddress byte, one data byte, then STOP. The subaddress does not auto-increment, so the first data byte is the only one taken. The register bank drives downstream logic as a flat parallel vector. A one-cycle write strobe also reports each committed write with its subaddress and data.

SCL and SDA are sampled on the system clock after a two-flop synchroniser. START and STOP are found by watching SDA move while SCL is high. The block only pulls SDA low; the pad does the open-drain release. Supply sensing is outside the block and arrives as the flag `por_active`. While that flag is high the target gives no acknowledge and writes nothing. Only the two mode bits of the mode register get known start values. The other register contents stay undefined until software writes them.

Top module: `defl_i2c_target`

## Requirements
- R1: The target acknowledges a device byte of 0x8C (7-bit address 0x46 with bit 0 = 0 for write). Any other device byte, including 0x8D (the read form), gets no acknowledge. After that the target acknowledges nothing until the next START.
- R2: A subaddress byte below NREGS (27 by default) is acknowledged. A subaddress byte of NREGS or above is not acknowledged, and nothing in that transaction is written.
- R3: A data byte that follows an accepted subaddress is acknowledged. At the SCL falling edge that ends the acknowledge clock, `wr_stb` pulses high for exactly one system clock, with `wr_addr` equal to the subaddress and `wr_data` equal to the data. The addressed register then holds that data.
- R4: Bytes sent after the data byte in the same transaction are not acknowledged, raise no strobe and change no register.
- R5: While `por_active` is high, no byte is acknowledged and no register is written. If `por_active` rises during an acknowledge, `sda_oe` drops on the next clock.
- R6: In the mode register (index MODE_IDX = 26), bits [1:0] read 2'b01 after `rst_n` and on every clock while `por_active` is high. Bits [7:2] of that register, and all other registers, keep whatever they held.
- R7: A START or STOP that arrives before a byte is complete abandons the transaction without a write. A START then begins a new device-byte phase.
- R8: `regs_o[8*i+7:8*i]` carries register i for every i below NREGS.
- R9: `sda_oe` changes only while SCL is low. The one exception is the forced release under R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_active | input | 1 | Power-on-reset flag from supply sensing; blocks acknowledge and writes |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| wr_stb | output | 1 | One-cycle pulse per committed register write |
| wr_addr | output | 8 | Subaddress of the last accepted write |
| wr_data | output | 8 | Data of the last accepted write |
| regs_o | output | NREGS*8 | Register bank, register i at bits [8i+7:8i] |

## Verification
The checker watches properties that hold on every cycle. The strobe is never longer than one cycle and never follows a cycle with `por_active` high. A strobed subaddress is always in range. The acknowledge drive falls right after `por_active` is seen. The mode bits read 2'b01 after a POR cycle. SDA drive changes only while SCL is low. Other behaviour needs whole transactions and only the bench scenarios can show it. This covers which of the 128 device addresses is acknowledged, the refusal of out-of-range subaddresses and of bytes after the data byte, transactions cut off by START or STOP mid-byte, and the contents of every register after a full write sweep.

// File: rtl/defl_i2c_pkg.sv
package defl_i2c_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SKIP
    } xfer_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_SUB,
        PH_DAT
    } byte_ph_e;

    typedef struct packed {
        logic [1:0] scl_m;
        logic [1:0] sda_m;
        logic       scl_p;
        logic       sda_p;
    } line_sync_s;

    typedef struct packed {
        xfer_st_e   st;
        byte_ph_e   ph;
        logic [7:0] sh;
        logic [3:0] cnt;
        logic [7:0] sub;
        logic [7:0] dat;
        logic       oe;
        logic       stb;
    } xfer_s;

endpackage

// File: rtl/defl_i2c_sync.sv
module defl_i2c_sync
    import defl_i2c_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    line_sync_s d, q;

    always_comb begin
        d       = q;
        d.scl_m = {q.scl_m[0], scl_i};
        d.sda_m = {q.sda_m[0], sda_i};
        d.scl_p = q.scl_m[1];
        d.sda_p = q.sda_m[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_m: 2'b11, sda_m: 2'b11, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign sda_s     = q.sda_m[1];
    assign scl_rise  = q.scl_m[1] & ~q.scl_p;
    assign scl_fall  = ~q.scl_m[1] & q.scl_p;
    assign bus_start = q.scl_m[1] & q.scl_p & q.sda_p & ~q.sda_m[1];
    assign bus_stop  = q.scl_m[1] & q.scl_p & ~q.sda_p & q.sda_m[1];

endmodule

// File: rtl/defl_i2c_xfer.sv
module defl_i2c_xfer
    import defl_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h46,
    parameter int         NREGS    = 27
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_active,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);

    localparam logic [7:0] LIMIT   = 8'(NREGS);
    localparam logic [7:0] DEV_WR  = {DEV_ADDR, 1'b0};
    localparam logic [3:0] BITS    = 4'd8;

    xfer_s d, q;
    logic  byte_ok;

    always_comb begin
        unique case (q.ph)
            PH_DEV:  byte_ok = (q.sh == DEV_WR);
            PH_SUB:  byte_ok = (q.sh < LIMIT);
            PH_DAT:  byte_ok = 1'b1;
            default: byte_ok = 1'b0;
        endcase
    end

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (bus_start) begin
            d.st  = ST_RECV;
            d.ph  = PH_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_RECV: begin
                    if (scl_rise && q.cnt != BITS) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BITS) begin
                        if (byte_ok && !por_active) begin
                            d.st = ST_ACK;
                            d.oe = 1'b1;
                        end else begin
                            d.st = ST_SKIP;
                        end
                        if (q.ph == PH_SUB) d.sub = q.sh;
                        if (q.ph == PH_DAT) d.dat = q.sh;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        unique case (q.ph)
                            PH_DEV: begin
                                d.ph = PH_SUB;
                                d.st = ST_RECV;
                            end
                            PH_SUB: begin
                                d.ph = PH_DAT;
                                d.st = ST_RECV;
                            end
                            default: begin
                                d.st  = ST_SKIP;
                                d.stb = 1'b1;
                            end
                        endcase
                    end
                end
                default: ;
            endcase
        end
        if (por_active) begin
            d.oe  = 1'b0;
            d.stb = 1'b0;
            if (d.st == ST_ACK) d.st = ST_SKIP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ph: PH_DEV, sh: '0, cnt: '0,
                   sub: '0, dat: '0, oe: 1'b0, stb: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_stb  = q.stb;
    assign wr_addr = q.sub;
    assign wr_data = q.dat;

endmodule

// File: rtl/defl_i2c_bank.sv
module defl_i2c_bank #(
    parameter int         NREGS    = 27,
    parameter int         MODE_IDX = 26,
    parameter logic [1:0] MODE_RST = 2'b01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_active,
    input  logic               wr_stb,
    input  logic [7:0]         wr_addr,
    input  logic [7:0]         wr_data,
    output logic [NREGS*8-1:0] regs_o
);

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        logic hit;
        assign hit = wr_stb && !por_active && (wr_addr == 8'(i));

        if (i == MODE_IDX) begin : g_mode
            logic [1:0] lo_q;
            logic [5:0] hi_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lo_q <= MODE_RST;
                end else if (por_active) begin
                    lo_q <= MODE_RST;
                end else if (hit) begin
                    lo_q <= wr_data[1:0];
                end
            end

            always_ff @(posedge clk) begin
                if (hit) hi_q <= wr_data[7:2];
            end

            assign regs_o[i*8 +: 8] = {hi_q, lo_q};
        end else begin : g_plain
            logic [7:0] r_q;

            always_ff @(posedge clk) begin
                if (hit) r_q <= wr_data;
            end

            assign regs_o[i*8 +: 8] = r_q;
        end
    end

endmodule

// File: rtl/defl_i2c_target.sv
module defl_i2c_target #(
    parameter logic [6:0] DEV_ADDR = 7'h46,
    parameter int         NREGS    = 27,
    parameter int         MODE_IDX = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_active,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic               wr_stb,
    output logic [7:0]         wr_addr,
    output logic [7:0]         wr_data,
    output logic [NREGS*8-1:0] regs_o
);

    logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    defl_i2c_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    defl_i2c_xfer #(
        .DEV_ADDR (DEV_ADDR),
        .NREGS    (NREGS)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_active (por_active),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .sda_oe     (sda_oe),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    defl_i2c_bank #(
        .NREGS    (NREGS),
        .MODE_IDX (MODE_IDX),
        .MODE_RST (2'b01)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_active (por_active),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .regs_o     (regs_o)
    );

endmodule

// File: rtl/defl_i2c_target_chk.sv
module defl_i2c_target_chk #(
    parameter int NREGS    = 27,
    parameter int MODE_IDX = 26
) (
    input logic               clk,
    input logic               rst_n,
    input logic               por_active,
    input logic               scl_rise,
    input logic               scl_fall,
    input logic               sda_oe,
    input logic               wr_stb,
    input logic [7:0]         wr_addr,
    input logic [NREGS*8-1:0] regs_o
);

    localparam logic [7:0] LIMIT = 8'(NREGS);

    logic scl_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_hi_q <= 1'b1;
        end else if (scl_rise) begin
            scl_hi_q <= 1'b1;
        end else if (scl_fall) begin
            scl_hi_q <= 1'b0;
        end
    end

    // R3
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R2
    stb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_addr < LIMIT));

    // R5
    por_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_active |=> !sda_oe);

    // R5
    por_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(por_active));

    // R6
    mode_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(por_active) |-> (regs_o[MODE_IDX*8 +: 2] == 2'b01));

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(por_active)) |-> !scl_hi_q);

endmodule

bind defl_i2c_target defl_i2c_target_chk #(
    .NREGS    (NREGS),
    .MODE_IDX (MODE_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_active (por_active),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_oe     (sda_oe),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .regs_o     (regs_o)
);

// File: tb/sim_defl_i2c_target.sv
`timescale 1ns/1ps
module sim_defl_i2c_target;

    localparam int NREGS    = 27;
    localparam int MODE_IDX = 26;
    localparam int T        = 6 * 20;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               por_active = 1'b0;
    logic               scl_m = 1'b1;
    logic               sda_m = 1'b1;
    logic               sda_bus;
    logic               sda_oe;
    logic               wr_stb;
    logic [7:0]         wr_addr;
    logic [7:0]         wr_data;
    logic [NREGS*8-1:0] regs_o;

    assign sda_bus = sda_m & ~sda_oe;

    defl_i2c_target u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_active (por_active),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .regs_o     (regs_o)
    );

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    int r9_bad = 0;
    logic [7:0] last_a, last_d;
    logic oe_p = 1'b0;
    logic [7:0] exp_r [NREGS];
    bit known [NREGS];
    bit done = 0;

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt++;
            last_a = wr_addr;
            last_d = wr_data;
        end
        if (rst_n && !por_active && sda_oe !== oe_p && scl_m) r9_bad++;
        oe_p = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #T;
        scl_m = 1'b1; #T;
        sda_m = 1'b0; #T;
        scl_m = 1'b0; #T;
    endtask

    task automatic bus_stop();
        scl_m = 1'b0;
        sda_m = 1'b0; #T;
        scl_m = 1'b1; #T;
        sda_m = 1'b1; #(2*T);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; #T;
            scl_m = 1'b1; #(2*T);
            scl_m = 1'b0; #T;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; #T;
        scl_m = 1'b1; #T;
        ack = !sda_bus; #T;
        scl_m = 1'b0; #T;
    endtask

    task automatic wr_txn(input logic [7:0] sub, input logic [7:0] dat,
                          output bit a0, output bit a1, output bit a2);
        bus_start();
        send_byte(8'h8C, a0);
        send_byte(sub, a1);
        send_byte(dat, a2);
        bus_stop();
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREGS; i++) begin
            if (known[i])
                chk(regs_o[i*8 +: 8] == exp_r[i], req, $sformatf("reg %0d", i),
                    regs_o[i*8 +: 8], exp_r[i]);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a0, a1, a2, a3;
        int base;
        for (int i = 0; i < NREGS; i++) begin
            known[i] = 0;
            exp_r[i] = '0;
        end
        #100;
        rst_n = 1'b1;
        #100;

        // R6 reset state of mode bits, idle outputs
        chk(regs_o[MODE_IDX*8 +: 2] == 2'b01, "R6", "mode bits after reset",
            regs_o[MODE_IDX*8 +: 2], 1);
        chk(sda_oe == 1'b0, "R6", "sda_oe after reset", sda_oe, 0);
        chk(wr_stb == 1'b0, "R6", "wr_stb after reset", wr_stb, 0);

        // R1 sweep over every 7-bit device address in write form
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({a[6:0], 1'b0}, a0);
            chk(a0 == (a == 'h46), "R1", $sformatf("ack for addr %0h", a), a0, a == 'h46);
            if (a != 'h46) begin
                send_byte(8'h8C, a1);
                chk(a1 == 0, "R1", "ack after rejected address", a1, 0);
            end
            bus_stop();
        end
        bus_start();
        send_byte(8'h8D, a0);
        chk(a0 == 0, "R1", "read form refused", a0, 0);
        bus_stop();
        chk(stb_cnt == 0, "R1", "no strobe during address sweep", stb_cnt, 0);

        // R3 R8 write every register
        for (int i = 0; i < NREGS; i++) begin
            logic [7:0] v;
            v = 8'((i * 53 + 17) & 255);
            base = stb_cnt;
            wr_txn(8'(i), v, a0, a1, a2);
            chk(a0 && a1 && a2, "R3", $sformatf("acks for reg %0d", i), {a0, a1, a2}, 7);
            chk(stb_cnt == base + 1, "R3", "one strobe", stb_cnt - base, 1);
            chk(last_a == 8'(i) && last_d == v, "R3", "strobe addr/data",
                {last_a, last_d}, {8'(i), v});
            exp_r[i] = v;
            known[i] = 1;
        end
        check_bank("R8");

        // R2 out-of-range subaddresses
        for (int s = NREGS; s < 33; s++) begin
            logic [7:0] sv;
            sv = (s == 32) ? 8'hFF : 8'(s);
            base = stb_cnt;
            wr_txn(sv, 8'h77, a0, a1, a2);
            chk(a0 && !a1 && !a2, "R2", $sformatf("acks for sub %0h", sv), {a0, a1, a2}, 4);
            chk(stb_cnt == base, "R2", "no strobe", stb_cnt - base, 0);
        end
        check_bank("R2");

        // R4 no auto-increment
        base = stb_cnt;
        bus_start();
        send_byte(8'h8C, a0);
        send_byte(8'd3, a1);
        send_byte(8'hA5, a2);
        send_byte(8'h5A, a3);
        chk(a3 == 0, "R4", "second data byte ack", a3, 0);
        send_byte(8'h3C, a3);
        chk(a3 == 0, "R4", "third data byte ack", a3, 0);
        bus_stop();
        chk(stb_cnt == base + 1, "R4", "strobe count", stb_cnt - base, 1);
        exp_r[3] = 8'hA5;
        check_bank("R4");

        // R5 R6 whole transaction under power-on reset
        por_active = 1'b1;
        #(4*T);
        exp_r[MODE_IDX][1:0] = 2'b01;
        chk(regs_o[MODE_IDX*8 +: 2] == 2'b01, "R6", "mode bits during por",
            regs_o[MODE_IDX*8 +: 2], 1);
        base = stb_cnt;
        wr_txn(8'd5, 8'h99, a0, a1, a2);
        chk(!a0 && !a1 && !a2, "R5", "acks during por", {a0, a1, a2}, 0);
        chk(stb_cnt == base, "R5", "no strobe during por", stb_cnt - base, 0);
        por_active = 1'b0;
        #(2*T);
        check_bank("R5");

        // R5 por rises between subaddress and data
        base = stb_cnt;
        bus_start();
        send_byte(8'h8C, a0);
        send_byte(8'd7, a1);
        por_active = 1'b1;
        send_byte(8'h42, a2);
        bus_stop();
        por_active = 1'b0;
        #(2*T);
        chk(a0 && a1 && !a2, "R5", "acks with late por", {a0, a1, a2}, 6);
        chk(stb_cnt == base, "R5", "no strobe with late por", stb_cnt - base, 0);
        check_bank("R5");

        // R7 STOP inside the data byte
        base = stb_cnt;
        bus_start();
        send_byte(8'h8C, a0);
        send_byte(8'd2, a1);
        send_bits(8'h0F, 4);
        bus_stop();
        chk(stb_cnt == base, "R7", "no strobe after mid-byte stop", stb_cnt - base, 0);
        check_bank("R7");

        // R7 START inside the data byte, then a new full write
        base = stb_cnt;
        bus_start();
        send_byte(8'h8C, a0);
        send_byte(8'd2, a1);
        send_bits(8'hF0, 5);
        bus_start();
        send_byte(8'h8C, a0);
        send_byte(8'd6, a1);
        send_byte(8'hC3, a2);
        bus_stop();
        chk(a0 && a1 && a2, "R7", "acks after restart", {a0, a1, a2}, 7);
        chk(stb_cnt == base + 1 && last_a == 8'd6 && last_d == 8'hC3, "R7",
            "single write after restart", {stb_cnt - base, last_a, last_d}, {1, 8'd6, 8'hC3});
        exp_r[6] = 8'hC3;
        check_bank("R7");

        // R9 SDA drive moved only while SCL was low
        chk(r9_bad == 0, "R9", "sda_oe changes with SCL high", r9_bad, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule